// File: doc/BRIEF.md
# Write-Reference Voltage Training Latch Sequencer

This block runs the three-write sequence that latches a new DRAM write reference voltage on one rank. A caller holds a base mode-register-6 word (reference value, range select and training-enable bit), a rank and an idle count, then pulses start. The sequencer captures all three values. It then asks a downstream command-pair generator for three mode-register-6 writes, one after another. The first two writes carry the base word with training enable forced high. The last write carries it with training enable forced low, which returns the DRAM to normal operation.

Each request names mode register 6, the rank, the payload and the idle count that the generator must place after each command. The generator turns every request into an A-side and a B-side command, so one full run yields six command words. The sequencer waits for the generator's completion pulse before it issues the next request. After the third completion it raises done for one cycle.

Top module: `vref_latch_seq`

## Requirements
- R1: After reset, req_o, busy_o and done_o are low.
- R2: A start pulse while idle raises req_o in the following cycle. req_o is high for exactly one cycle per request, and req_mr_sel_o is 6 whenever req_o is high.
- R3: The first request carries the captured base word with bit 7 (training enable) set to 1. Bits 5:0 (reference value), bit 6 (range) and all other bits stay unchanged.
- R4: The second request carries exactly the same payload as the first.
- R5: The third request carries the captured base word with bit 7 cleared to 0 and all other bits unchanged.
- R6: Every request carries the rank and idle count captured at start, even if those inputs change later.
- R7: After a request, no further request is issued until pair_done_i has been high for a cycle. The next request follows in the cycle after that pulse.
- R8: done_o is high for exactly one cycle, the cycle after pair_done_i answers the third request. busy_o is low in that cycle, and exactly three requests precede it.
- R9: A start pulse while busy is ignored: captured values, step order and request count are unaffected.
- R10: A pair_done_i pulse while idle produces no request and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| base_mr_i | input | ADDR_W (14) | Base mode-register-6 word, sampled at start |
| rank_i | input | RANK_W (2) | Target rank, sampled at start |
| idle_cycles_i | input | IDLE_W (16) | Reference-enter delay in cycles, sampled at start |
| pair_done_i | input | 1 | Completion pulse from the pair generator |
| req_o | output | 1 | One-cycle request to the pair generator |
| req_mr_sel_o | output | MRSEL_W (3) | Mode register number, always 6 |
| req_payload_o | output | ADDR_W (14) | Address payload for the current step |
| req_rank_o | output | RANK_W (2) | Captured rank |
| req_idle_o | output | IDLE_W (16) | Captured idle count |
| busy_o | output | 1 | High while a sequence is in flight |
| done_o | output | 1 | One-cycle pulse when the sequence ends |

## Verification
Base words of all zeros and all ones are run directly. The all-ones word shows that the last step really clears the enable bit; the all-zeros word shows that the first two steps set it. Random base words, ranks, idle counts and generator latencies of one to six cycles separate correct bit forcing from disturbance of neighbouring bits, and show that the step order holds under any answer delay. Some runs put a start pulse in the wait window and change the inputs after capture. A stray completion pulse is given while idle to separate ignored stimulus from a restarted or corrupted sequence.

// File: rtl/vref_seq_pkg.sv
package vref_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/vref_step_ctrl.sv
module vref_step_ctrl
    import vref_seq_pkg::*;
#(
    parameter int NUM_STEPS = 3,
    localparam int STEP_W   = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pair_done_i,
    output logic              capture_o,
    output logic              req_o,
    output logic              last_step_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEPS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [STEP_W-1:0] step;
        logic              done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        capture_o   = 1'b0;
        case (ctrl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_d.st   = ST_ISSUE;
                    ctrl_d.step = '0;
                    capture_o   = 1'b1;
                end
            end
            ST_ISSUE: ctrl_d.st = ST_WAIT;
            ST_WAIT: begin
                if (pair_done_i) begin
                    if (ctrl_q.step == LAST) begin
                        ctrl_d.st   = ST_IDLE;
                        ctrl_d.done = 1'b1;
                    end else begin
                        ctrl_d.step = ctrl_q.step + 1'b1;
                        ctrl_d.st   = ST_ISSUE;
                    end
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, step: '0, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign req_o       = (ctrl_q.st == ST_ISSUE);
    assign busy_o      = (ctrl_q.st != ST_IDLE);
    assign last_step_o = (ctrl_q.step == LAST);
    assign done_o      = ctrl_q.done;
endmodule

// File: rtl/vref_cfg_hold.sv
module vref_cfg_hold #(
    parameter int ADDR_W = 14,
    parameter int RANK_W = 2,
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [RANK_W-1:0] rank_i,
    input  logic [IDLE_W-1:0] idle_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [RANK_W-1:0] rank_o,
    output logic [IDLE_W-1:0] idle_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [RANK_W-1:0] rank;
        logic [IDLE_W-1:0] idle;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (capture_i) begin
            cfg_d.base = base_i;
            cfg_d.rank = rank_i;
            cfg_d.idle = idle_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign base_o = cfg_q.base;
    assign rank_o = cfg_q.rank;
    assign idle_o = cfg_q.idle;
endmodule

// File: rtl/vref_mr6_format.sv
module vref_mr6_format #(
    parameter int ADDR_W = 14,
    parameter int TE_BIT = 7
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic              last_step_i,
    output logic [ADDR_W-1:0] payload_o
);
    localparam logic [ADDR_W-1:0] TE_MASK = ADDR_W'(1) << TE_BIT;

    always_comb begin
        if (last_step_i) begin
            payload_o = base_i & ~TE_MASK;
        end else begin
            payload_o = base_i | TE_MASK;
        end
    end
endmodule

// File: rtl/vref_latch_seq.sv
module vref_latch_seq #(
    parameter int ADDR_W    = 14,
    parameter int RANK_W    = 2,
    parameter int IDLE_W    = 16,
    parameter int MRSEL_W   = 3,
    parameter int MR_NUM    = 6,
    parameter int TE_BIT    = 7,
    parameter int NUM_STEPS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [ADDR_W-1:0]  base_mr_i,
    input  logic [RANK_W-1:0]  rank_i,
    input  logic [IDLE_W-1:0]  idle_cycles_i,
    input  logic               pair_done_i,
    output logic               req_o,
    output logic [MRSEL_W-1:0] req_mr_sel_o,
    output logic [ADDR_W-1:0]  req_payload_o,
    output logic [RANK_W-1:0]  req_rank_o,
    output logic [IDLE_W-1:0]  req_idle_o,
    output logic               busy_o,
    output logic               done_o
);
    logic              capture;
    logic              last_step;
    logic [ADDR_W-1:0] base_held;

    vref_step_ctrl #(.NUM_STEPS(NUM_STEPS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .pair_done_i(pair_done_i),
        .capture_o  (capture),
        .req_o      (req_o),
        .last_step_o(last_step),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    vref_cfg_hold #(.ADDR_W(ADDR_W), .RANK_W(RANK_W), .IDLE_W(IDLE_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture_i(capture),
        .base_i   (base_mr_i),
        .rank_i   (rank_i),
        .idle_i   (idle_cycles_i),
        .base_o   (base_held),
        .rank_o   (req_rank_o),
        .idle_o   (req_idle_o)
    );

    vref_mr6_format #(.ADDR_W(ADDR_W), .TE_BIT(TE_BIT)) u_fmt (
        .base_i     (base_held),
        .last_step_i(last_step),
        .payload_o  (req_payload_o)
    );

    assign req_mr_sel_o = MRSEL_W'(MR_NUM);
endmodule

// File: rtl/vref_latch_seq_chk.sv
module vref_latch_seq_chk #(
    parameter int ADDR_W  = 14,
    parameter int RANK_W  = 2,
    parameter int IDLE_W  = 16,
    parameter int MRSEL_W = 3,
    parameter int MR_NUM  = 6,
    parameter int TE_BIT  = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               pair_done_i,
    input logic               req_o,
    input logic [MRSEL_W-1:0] req_mr_sel_o,
    input logic [ADDR_W-1:0]  req_payload_o,
    input logic [RANK_W-1:0]  req_rank_o,
    input logic [IDLE_W-1:0]  req_idle_o,
    input logic               busy_o,
    input logic               done_o
);
    logic [2:0] req_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_cnt <= '0;
        end else if (done_o) begin
            req_cnt <= '0;
        end else if (req_o) begin
            req_cnt <= req_cnt + 3'd1;
        end
    end

    a_r2_issue_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> req_o);
    a_r2_mr_select: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (req_mr_sel_o == MRSEL_W'(MR_NUM)));
    a_r3_enable_early: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && req_cnt < 3'd2) |-> req_payload_o[TE_BIT]);
    a_r5_disable_last: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && req_cnt == 3'd2) |-> !req_payload_o[TE_BIT]);
    a_r6_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(req_rank_o) && $stable(req_idle_o)));
    a_r7_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> ($past(start_i) || $past(pair_done_i)));
    a_r8_done_count: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (req_cnt == 3'd3 && !busy_o));
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind vref_latch_seq vref_latch_seq_chk #(
    .ADDR_W(ADDR_W), .RANK_W(RANK_W), .IDLE_W(IDLE_W),
    .MRSEL_W(MRSEL_W), .MR_NUM(MR_NUM), .TE_BIT(TE_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .pair_done_i  (pair_done_i),
    .req_o        (req_o),
    .req_mr_sel_o (req_mr_sel_o),
    .req_payload_o(req_payload_o),
    .req_rank_o   (req_rank_o),
    .req_idle_o   (req_idle_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/vref_latch_seq_bench.sv
module vref_latch_seq_bench;
    localparam int ADDR_W = 14;
    localparam int RANK_W = 2;
    localparam int IDLE_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] base_mr_i = '0;
    logic [RANK_W-1:0] rank_i = '0;
    logic [IDLE_W-1:0] idle_cycles_i = '0;
    logic              pair_done_i = 1'b0;
    logic              req_o;
    logic [2:0]        req_mr_sel_o;
    logic [ADDR_W-1:0] req_payload_o;
    logic [RANK_W-1:0] req_rank_o;
    logic [IDLE_W-1:0] req_idle_o;
    logic              busy_o;
    logic              done_o;

    int checks = 0;
    int errors = 0;

    vref_latch_seq u_vref_latch_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_mr_i(base_mr_i),
        .rank_i(rank_i), .idle_cycles_i(idle_cycles_i), .pair_done_i(pair_done_i),
        .req_o(req_o), .req_mr_sel_o(req_mr_sel_o), .req_payload_o(req_payload_o),
        .req_rank_o(req_rank_o), .req_idle_o(req_idle_o), .busy_o(busy_o), .done_o(done_o)
    );

    always #10 clk = ~clk;

    function automatic logic [ADDR_W-1:0] exp_payload(input logic [ADDR_W-1:0] b, input int step);
        logic [ADDR_W-1:0] r;
        r = b;
        r[7] = (step < 2);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_seq(input logic [ADDR_W-1:0] base, input logic [RANK_W-1:0] rank,
                           input logic [IDLE_W-1:0] idle, input int lat, input bit poke);
        @(negedge clk);
        start_i = 1'b1; base_mr_i = base; rank_i = rank; idle_cycles_i = idle;
        @(negedge clk);
        start_i = 1'b0; base_mr_i = ~base; rank_i = ~rank; idle_cycles_i = ~idle;
        for (int s = 0; s < 3; s++) begin
            chk(req_o == 1'b1, "R2/R7 request issued", 32'(req_o), 1);
            chk(req_mr_sel_o == 3'd6, "R2 mode register select", 32'(req_mr_sel_o), 6);
            chk(req_payload_o == exp_payload(base, s),
                (s == 0) ? "R3 first payload" : (s == 1) ? "R4 second payload" : "R5 last payload",
                32'(req_payload_o), 32'(exp_payload(base, s)));
            chk(req_rank_o == rank && req_idle_o == idle, "R6 captured rank and idle",
                {req_rank_o, req_idle_o}, {rank, idle});
            chk(busy_o == 1'b1, "R8 busy during sequence", 32'(busy_o), 1);
            @(negedge clk);
            chk(req_o == 1'b0, "R2 single-cycle request", 32'(req_o), 0);
            for (int l = 0; l < lat; l++) begin
                if (poke && l == 0) start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                chk(req_o == 1'b0 && done_o == 1'b0, "R7/R9 quiet while waiting",
                    {req_o, done_o}, 0);
            end
            pair_done_i = 1'b1;
            @(negedge clk);
            pair_done_i = 1'b0;
            if (s == 2) begin
                chk(done_o == 1'b1 && busy_o == 1'b0, "R8 done pulse after third answer",
                    {done_o, busy_o}, 2);
            end else begin
                chk(done_o == 1'b0, "R8 no early done", 32'(done_o), 0);
            end
        end
        @(negedge clk);
        chk(done_o == 1'b0 && req_o == 1'b0 && busy_o == 1'b0, "R8/R9 single done, no restart",
            {done_o, req_o, busy_o}, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5EED_0006));
        repeat (2) @(negedge clk);
        chk(req_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, "R1 reset state",
            {req_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, "R1 idle after reset",
            {req_o, busy_o, done_o}, 0);

        pair_done_i = 1'b1;
        @(negedge clk);
        pair_done_i = 1'b0;
        chk(req_o == 1'b0 && done_o == 1'b0 && busy_o == 1'b0, "R10 stray answer while idle",
            {req_o, done_o, busy_o}, 0);
        @(negedge clk);
        chk(req_o == 1'b0 && done_o == 1'b0, "R10 still idle", {req_o, done_o}, 0);

        run_seq('0, 2'd0, 16'd10, 1, 1'b0);
        run_seq('1, 2'd3, 16'hFFFF, 2, 1'b1);
        run_seq(14'h0055, 2'd1, 16'd0, 3, 1'b0);

        for (int i = 0; i < 25; i++) begin
            run_seq(ADDR_W'($urandom), RANK_W'($urandom), IDLE_W'($urandom),
                    1 + int'($urandom % 6), bit'($urandom % 2));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule